// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It keeps a set-associative table of branch targets. Each set holds several ways, and each way holds a tag, a target address and a valid bit. A branch looks up the table with a set index. The index is a hash of three things: the word-aligned branch address, a global history value and a short list of recently taken path targets. The tag is a slice of the aligned branch address. A hit returns the stored target one clock after the request.

When the branch resolves, the update port writes the resolved target back. The update port uses the history and path snapshot that was captured when the prediction was made, so it reaches the same set the lookup used. If a valid way in that set already holds the same tag, its target is overwritten. Otherwise a way is allocated and both its tag and its target are written. An empty way is filled first. Once the set is full, a free-running LFSR picks the way to replace. The history and path inputs are produced elsewhere in the pipeline.

Top module: `itp_predictor`

## Requirements
- R1: The set index is the low log2(SETS) bits of ((addr >> SHIFT) XOR hist XOR, for each path slot p from 0 (newest) to PATH_N-1, (path[p] >> (SHIFT + p*(log2(SETS)/PATH_N)))). With the defaults this is ((addr>>2) ^ hist ^ (p0>>2) ^ (p1>>4)) & 15. Path slot p sits in bits [p*ADDR_W +: ADDR_W] of the path bus.
- R2: The tag is bits [SHIFT +: TAG_W] of the branch address, so addresses that differ only below bit SHIFT, or only above bit SHIFT+TAG_W-1, alias to the same entry when they also index the same set.
- R3: A lookup hits only on a way that is valid and whose tag matches. Reset clears every valid bit, so after reset every lookup misses, including one whose tag is zero.
- R4: The lookup result appears on lk_hit and lk_target at the first rising edge after a cycle with lk_valid high. lk_hit is 0 after any cycle with lk_valid low, and lk_target then holds its previous value.
- R5: An update whose tag matches a valid way in the indexed set rewrites only that way's target. Other entries in the set are kept.
- R6: An update with no matching way allocates a way and writes its tag and target. The lowest-numbered invalid way is used if there is one, and nothing valid is displaced.
- R7: When the indexed set is full, allocation replaces exactly one way, picked by the LFSR. After WAYS+1 distinct tags are written into one set, exactly WAYS of them hit, and the newest one is always among them.
- R8: A lookup and an update in the same cycle follow read-before-write ordering: the lookup returns the table contents as they were before that update.
- R9: The update port computes its set from its own up_hist and up_path snapshot and ignores the values on the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_hist | input | HIST_W | Current global history |
| lk_path | input | PATH_N*ADDR_W | Recent path targets, slot 0 newest |
| lk_hit | output | 1 | Registered hit flag |
| lk_target | output | ADDR_W | Registered predicted target |
| up_valid | input | 1 | Update request |
| up_addr | input | ADDR_W | Resolved branch address |
| up_hist | input | HIST_W | History snapshot taken at prediction |
| up_path | input | PATH_N*ADDR_W | Path snapshot taken at prediction |
| up_target | input | ADDR_W | Resolved target |

## Verification
A lookup driven before a rising edge is answered by the registers at that edge. The bench drives every request on a falling edge and reads lk_hit and lk_target on the next falling edge, which is exactly one register stage later. An update is committed at the rising edge it is presented on, so a lookup issued in the following cycle must already see it. In the same-cycle case, the answer is the pre-update value, and the lookup one cycle later shows the new target. The expected results come from a bench model of the table. That model treats a set as exact while it holds at most WAYS tags. Once a set overflows, the model only requires that any hit returns the most recently written target.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int LFSR_W = 8;
  // Galois polynomial x^8 + x^6 + x^5 + x^4 + 1, maximal length
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int ADDR_W    = 32,
  parameter int HIST_W    = 8,
  parameter int PATH_N    = 2,
  parameter int SET_W     = 4,
  parameter int TAG_W     = 10,
  parameter int SHIFT     = 2,
  parameter int HASH_HIST = 1,
  parameter int HASH_PATH = 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [HIST_W-1:0]        hist,
  input  logic [PATH_N*ADDR_W-1:0] path,
  output logic [SET_W-1:0]         set_idx,
  output logic [TAG_W-1:0]         tag
);
  localparam int STEP = SET_W / PATH_N;

  logic [PATH_N:0][ADDR_W-1:0] fold;

  // Base term: aligned address, optionally folded with global history
  if (HASH_HIST != 0) begin : g_hist
    assign fold[0] = (addr >> SHIFT) ^ ADDR_W'(hist);
  end else begin : g_nohist
    assign fold[0] = addr >> SHIFT;
  end

  // Newest path target first, each older one shifted further right
  for (genvar p = 0; p < PATH_N; p++) begin : g_path
    if (HASH_PATH != 0) begin : g_on
      assign fold[p+1] = fold[p] ^ (path[p*ADDR_W +: ADDR_W] >> (SHIFT + p*STEP));
    end else begin : g_off
      assign fold[p+1] = fold[p];
    end
  end

  assign set_idx = fold[PATH_N][SET_W-1:0];
  assign tag     = addr[SHIFT +: TAG_W];
endmodule

// File: rtl/itp_lfsr.sv
module itp_lfsr import itp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] value
);
  logic [LFSR_W-1:0] lfsr_d, lfsr_q;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R7
endmodule

// File: rtl/itp_way_match.sv
module itp_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valids,
  input  logic [TAG_W-1:0]           probe,
  output logic [WAYS-1:0]            match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valids[w] && (tags[w] == probe);
  end
endmodule

// File: rtl/itp_victim.sv
module itp_victim import itp_pkg::*; #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]   valids,
  input  logic [LFSR_W-1:0] rnd,
  output logic [WAYS-1:0]   pick
);
  logic found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valids[w] && !found) begin
        pick[w] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found) pick = WAYS'(1) << (rnd % WAYS);
  end
endmodule

// File: rtl/itp_predictor.sv
module itp_predictor import itp_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int HIST_W    = 8,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int TAG_W     = 10,
  parameter int PATH_N    = 2,
  parameter int SHIFT     = 2,
  parameter int HASH_HIST = 1,
  parameter int HASH_PATH = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [HIST_W-1:0]        lk_hist,
  input  logic [PATH_N*ADDR_W-1:0] lk_path,
  output logic                     lk_hit,
  output logic [ADDR_W-1:0]        lk_target,
  input  logic                     up_valid,
  input  logic [ADDR_W-1:0]        up_addr,
  input  logic [HIST_W-1:0]        up_hist,
  input  logic [PATH_N*ADDR_W-1:0] up_path,
  input  logic [ADDR_W-1:0]        up_target
);
  localparam int SET_W = $clog2(SETS);

  // Table storage; only valid bits are reset
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] tgt_q   [SETS];
  logic [WAYS-1:0]             valid_q [SETS];

  logic [SET_W-1:0]  lk_set, up_set;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic [WAYS-1:0]   lk_match, up_match, victim_oh, wr_oh;
  logic [LFSR_W-1:0] rnd;
  logic [ADDR_W-1:0] lk_sel_tgt;
  logic              hit_d;
  logic [ADDR_W-1:0] target_d;

  itp_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_N(PATH_N), .SET_W(SET_W),
             .TAG_W(TAG_W), .SHIFT(SHIFT), .HASH_HIST(HASH_HIST),
             .HASH_PATH(HASH_PATH))
    u_lk_hash (.addr(lk_addr), .hist(lk_hist), .path(lk_path),
               .set_idx(lk_set), .tag(lk_tag));

  itp_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_N(PATH_N), .SET_W(SET_W),
             .TAG_W(TAG_W), .SHIFT(SHIFT), .HASH_HIST(HASH_HIST),
             .HASH_PATH(HASH_PATH))
    u_up_hash (.addr(up_addr), .hist(up_hist), .path(up_path),
               .set_idx(up_set), .tag(up_tag));

  itp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W))
    u_lk_match (.tags(tag_q[lk_set]), .valids(valid_q[lk_set]),
                .probe(lk_tag), .match(lk_match));

  itp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W))
    u_up_match (.tags(tag_q[up_set]), .valids(valid_q[up_set]),
                .probe(up_tag), .match(up_match));

  itp_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .step(1'b1), .value(rnd));

  itp_victim #(.WAYS(WAYS))
    u_victim (.valids(valid_q[up_set]), .rnd(rnd), .pick(victim_oh));

  // Lookup next state: reads the table before any same-edge write
  always_comb begin
    lk_sel_tgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) lk_sel_tgt = lk_sel_tgt | tgt_q[lk_set][w];
    end
    hit_d    = lk_valid && (|lk_match);
    target_d = lk_valid ? lk_sel_tgt : lk_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit    <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_hit    <= hit_d;
      lk_target <= target_d;
    end
  end

  // Update: matching way wins, otherwise the victim picker chooses
  assign wr_oh = (|up_match) ? up_match : victim_oh;

  always_ff @(posedge clk) begin
    if (up_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_oh[w]) begin
          tag_q[up_set][w] <= up_tag;
          tgt_q[up_set][w] <= up_target;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (up_valid) begin
      valid_q[up_set] <= valid_q[up_set] | wr_oh;
    end
  end

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid)); // R4
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lk_target)); // R4
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_ONE_WAY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> $onehot(wr_oh)); // R6
endmodule

// File: tb/itp_predictor_test.sv
module itp_predictor_test;
  localparam int AW = 32;
  localparam int NS = 16;
  localparam int NW = 4;
  localparam int TW = 10;

  logic          clk, rst_n;
  logic          lk_valid, up_valid;
  logic [AW-1:0] lk_addr, up_addr, up_target, lk_target;
  logic [7:0]    lk_hist, up_hist;
  logic [2*AW-1:0] lk_path, up_path;
  logic          lk_hit;

  int n_checks = 0;
  int n_fail   = 0;

  bit          m_valid [NS][1024];
  logic [AW-1:0] m_tgt [NS][1024];
  int          m_cnt   [NS];
  bit          m_lossy [NS];

  itp_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hist(lk_hist), .lk_path(lk_path),
    .lk_hit(lk_hit), .lk_target(lk_target),
    .up_valid(up_valid), .up_addr(up_addr), .up_hist(up_hist), .up_path(up_path),
    .up_target(up_target)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int f_set(logic [AW-1:0] a, logic [7:0] h, logic [AW-1:0] p0, logic [AW-1:0] p1);
    logic [AW-1:0] x;
    x = (a >> 2) ^ {24'd0, h} ^ (p0 >> 2) ^ (p1 >> 4);
    return int'(x[3:0]);
  endfunction

  function automatic int f_tag(logic [AW-1:0] a);
    return int'(a[11:2]);
  endfunction

  task automatic check(bit ok, string req, logic [AW:0] act, logic [AW:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [AW-1:0] a, logic [7:0] h, logic [AW-1:0] p0, logic [AW-1:0] p1, logic [AW-1:0] t);
    int s, g;
    s = f_set(a, h, p0, p1);
    g = f_tag(a);
    if (!m_valid[s][g]) begin
      m_valid[s][g] = 1'b1;
      m_cnt[s]++;
      if (m_cnt[s] > NW) m_lossy[s] = 1'b1;
    end
    m_tgt[s][g] = t;
  endtask

  task automatic update(logic [AW-1:0] a, logic [7:0] h, logic [AW-1:0] p0, logic [AW-1:0] p1, logic [AW-1:0] t);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_hist = h; up_path = {p1, p0}; up_target = t;
    @(negedge clk);
    up_valid = 1'b0;
    model_write(a, h, p0, p1, t);
  endtask

  // Issue lookup, read registered result one cycle later
  task automatic lookup(logic [AW-1:0] a, logic [7:0] h, logic [AW-1:0] p0, logic [AW-1:0] p1,
                        output logic hit, output logic [AW-1:0] tgt);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_hist = h; lk_path = {p1, p0};
    @(negedge clk);
    hit = lk_hit; tgt = lk_target;
    lk_valid = 1'b0;
  endtask

  task automatic lookup_model(logic [AW-1:0] a, logic [7:0] h, logic [AW-1:0] p0, logic [AW-1:0] p1, string req);
    logic hit;
    logic [AW-1:0] tgt;
    int s, g;
    s = f_set(a, h, p0, p1);
    g = f_tag(a);
    lookup(a, h, p0, p1, hit, tgt);
    if (!m_valid[s][g]) check(hit == 1'b0, req, {hit, tgt}, {1'b0, tgt});
    else if (!m_lossy[s]) check(hit && tgt == m_tgt[s][g], req, {hit, tgt}, {1'b1, m_tgt[s][g]});
    else if (hit) check(tgt == m_tgt[s][g], req, {hit, tgt}, {1'b1, m_tgt[s][g]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic hit;
    logic [AW-1:0] tgt, held;
    logic [AW-1:0] pa [24];
    logic [7:0]    ph [24];
    logic [AW-1:0] pp0 [24];
    logic [AW-1:0] pp1 [24];
    int hits;
    void'($urandom(32'd1234));
    for (int s = 0; s < NS; s++) begin
      m_cnt[s] = 0; m_lossy[s] = 1'b0;
      for (int g = 0; g < 1024; g++) m_valid[s][g] = 1'b0;
    end
    rst_n = 1'b0; lk_valid = 0; up_valid = 0;
    lk_addr = 0; lk_hist = 0; lk_path = 0;
    up_addr = 0; up_hist = 0; up_path = 0; up_target = 0;
    repeat (3) @(negedge clk);
    check(lk_hit == 1'b0, "R3 reset hit", {1'b0, lk_hit}, 0);
    rst_n = 1'b1;

    // R3: zero tag after reset misses
    lookup(32'h0, 8'h0, 0, 0, hit, tgt);
    check(hit == 1'b0, "R3 zero tag after reset", {1'b0, hit}, 0);

    // R6: allocate A, then hit
    update(32'h100, 8'h03, 32'h40, 32'h80, 32'hAAAA_0000);
    lookup_model(32'h100, 8'h03, 32'h40, 32'h80, "R6 allocate A");
    // R6: B same set, different tag; A kept
    check(f_set(32'h140, 8'h03, 32'h40, 32'h80) == f_set(32'h100, 8'h03, 32'h40, 32'h80), "R6 same set setup", 0, 0);
    update(32'h140, 8'h03, 32'h40, 32'h80, 32'hBBBB_0000);
    lookup_model(32'h100, 8'h03, 32'h40, 32'h80, "R6 A kept");
    lookup_model(32'h140, 8'h03, 32'h40, 32'h80, "R6 B present");

    // R4: idle lookup gives no hit, target held
    held = lk_target;
    @(negedge clk);
    @(negedge clk);
    check(lk_hit == 1'b0, "R4 idle no hit", {1'b0, lk_hit}, 0);
    check(lk_target == held, "R4 target held", {1'b0, lk_target}, {1'b0, held});

    // R1: history bit moves set -> miss
    lookup(32'h100, 8'h01, 32'h40, 32'h80, hit, tgt);
    check(hit == 1'b0, "R1 history changes set", {1'b0, hit}, 0);
    // R1: slot1 change by 1<<4 moves set; by 1<<3 is shifted out
    lookup(32'h100, 8'h03, 32'h40, 32'h90, hit, tgt);
    check(hit == 1'b0, "R1 path slot1 bit4", {1'b0, hit}, 0);
    lookup(32'h100, 8'h03, 32'h40, 32'h88, hit, tgt);
    check(hit && tgt == 32'hAAAA_0000, "R1 path slot1 bit3 ignored", {hit, tgt}, {1'b1, 32'hAAAA_0000});
    lookup(32'h100, 8'h03, 32'h44, 32'h80, hit, tgt);
    check(hit == 1'b0, "R1 path slot0 bit2", {1'b0, hit}, 0);

    // R2: aliasing below and above the tag slice
    lookup(32'h103, 8'h03, 32'h40, 32'h80, hit, tgt);
    check(hit && tgt == 32'hAAAA_0000, "R2 low bits alias", {hit, tgt}, {1'b1, 32'hAAAA_0000});
    lookup(32'h1100, 8'h03, 32'h40, 32'h80, hit, tgt);
    check(hit && tgt == 32'hAAAA_0000, "R2 high bits alias", {hit, tgt}, {1'b1, 32'hAAAA_0000});

    // R5: overwrite A target, B kept
    update(32'h100, 8'h03, 32'h40, 32'h80, 32'hCCCC_0000);
    lookup_model(32'h100, 8'h03, 32'h40, 32'h80, "R5 overwrite A");
    lookup_model(32'h140, 8'h03, 32'h40, 32'h80, "R5 B kept");

    // R8: same-cycle lookup and update of A
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h100; lk_hist = 8'h03; lk_path = {32'h80, 32'h40};
    up_valid = 1'b1; up_addr = 32'h100; up_hist = 8'h03; up_path = {32'h80, 32'h40}; up_target = 32'hDDDD_0000;
    @(negedge clk);
    check(lk_hit && lk_target == 32'hCCCC_0000, "R8 read before write", {lk_hit, lk_target}, {1'b1, 32'hCCCC_0000});
    lk_valid = 1'b0; up_valid = 1'b0;
    model_write(32'h100, 8'h03, 32'h40, 32'h80, 32'hDDDD_0000);
    lookup_model(32'h100, 8'h03, 32'h40, 32'h80, "R8 new value next cycle");

    // R9: update uses its own snapshot, not lookup-port history
    @(negedge clk);
    lk_hist = 8'hAA; lk_addr = 32'h200; lk_path = 0;
    up_valid = 1'b1; up_addr = 32'h200; up_hist = 8'h55; up_path = 0; up_target = 32'hEEEE_0000;
    @(negedge clk);
    up_valid = 1'b0;
    model_write(32'h200, 8'h55, 0, 0, 32'hEEEE_0000);
    lookup(32'h200, 8'h55, 0, 0, hit, tgt);
    check(hit && tgt == 32'hEEEE_0000, "R9 snapshot set hit", {hit, tgt}, {1'b1, 32'hEEEE_0000});
    lookup(32'h200, 8'hAA, 0, 0, hit, tgt);
    check(hit == 1'b0, "R9 live history set miss", {1'b0, hit}, 0);

    // R7: five tags into one set -> exactly four survive, newest among them
    for (int k = 0; k < 5; k++) update(32'h0300 + k*32'h40, 8'h00, 0, 0, 32'h7000 + k);
    hits = 0;
    for (int k = 0; k < 5; k++) begin
      lookup(32'h0300 + k*32'h40, 8'h00, 0, 0, hit, tgt);
      if (hit) begin
        hits++;
        check(tgt == 32'h7000 + k, "R7 survivor target", {1'b0, tgt}, {1'b0, 32'h7000 + k});
      end
      if (k == 4) check(hit == 1'b1, "R7 newest present", {1'b0, hit}, 1);
    end
    check(hits == NW, "R7 survivor count", hits, NW);

    // Random mix over a pool of tuples
    for (int i = 0; i < 24; i++) begin
      pa[i]  = {20'd0, 10'($urandom % 40), 2'($urandom)} + 32'h2000;
      ph[i]  = 8'($urandom % 4);
      pp0[i] = 32'($urandom % 8) << 2;
      pp1[i] = 32'($urandom % 4) << 4;
    end
    for (int i = 0; i < 400; i++) begin
      int j;
      j = int'($urandom % 24);
      if ($urandom % 2 == 0)
        update(pa[j], ph[j], pp0[j], pp1[j], $urandom);
      else
        lookup_model(pa[j], ph[j], pp0[j], pp1[j], "R1 R5 R6 random mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule